// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the fetch address of a small microcontroller whose program memory is 16K words, split into sixteen pages of 1K words each. Page n covers addresses n*0x400 to n*0x400+0x3FF. A 14-bit program counter is updated once per clock, which is one instruction cycle. With no transfer strobe active, the counter steps forward by one.

Control transfers come in as separate strobes from the instruction decoder: jump, call, return, move-to-PC, add-to-PC and table-add. The operands are a 10-bit in-page target, an 8-bit accumulator value and a 4-bit page-select field taken from the status register. Only some transfers take the page field. The two accumulator writes clear address bits 9:8, and the table-add keeps those bits.

Calls save the return address on an 8-deep ring of slots. Returns take the address back from that ring. A ninth push overwrites the oldest entry. Popping past the bottom wraps around the ring and raises no error. The fetch address comes straight from a register.

Top module: `pcs_pc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the fetch address becomes 0x0000 and the return stack becomes empty, so its write pointer is back at slot 0.
- R2: In a cycle with no strobe active, the fetch address becomes the previous address plus one, modulo 2^14. This means 0x3FFF is followed by 0x0000.
- R3: A jump loads address bits 13:10 from `page_sel` and bits 9:0 from `target`.
- R4: A call pushes the current fetch address plus one (modulo 2^14) onto the return stack. It then loads the address as a jump does. At most one strobe may be high in any cycle.
- R5: A return loads the full 14-bit address from the most recently pushed entry that has not yet been popped, and removes that entry.
- R6: A move-to-PC gives the address {`page_sel`, 2'b00, `acc`}.
- R7: An add-to-PC gives the address {`page_sel`, 2'b00, (addr[7:0] + `acc`) mod 256}. Any carry out of bit 7 is dropped.
- R8: A table-add gives the address {addr[13:8], (addr[7:0] + `acc`) mod 256}. Bits 13:8, including bits 9:8, are unchanged, and the page field is not used.
- R9: The stack is a ring of 8 slots. Each push writes the slot at the pointer and advances it by one, modulo 8. Each pop reads the slot just below the pointer and moves the pointer back, modulo 8. A ninth push therefore overwrites the oldest entry, and pops past the bottom return entries again in ring order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one instruction cycle per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| do_jump | input | 1 | Jump strobe |
| do_call | input | 1 | Call strobe |
| do_return | input | 1 | Return strobe (covers all return flavours) |
| do_move | input | 1 | Move-accumulator-to-PC strobe |
| do_add | input | 1 | Add-accumulator-to-PC strobe |
| do_table | input | 1 | Table-add strobe |
| target | input | 10 | In-page immediate target |
| acc | input | 8 | Accumulator value |
| page_sel | input | 4 | Page-select field from the status register |
| fetch_addr | output | 14 | Registered program fetch address |

## Verification
A call both writes a ring slot and loads a new address in the same edge. The slot receives the old address plus one, while the jump-style target goes to the counter. A return that follows directly in the next cycle must then read the slot that was just written. The bench provokes this with back-to-back call/return pairs, both at the ring's wrap point and in a long mixed-strobe run. It judges the result against a behavioural ring model on every clock.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_MOV  = 3'd4,
    OP_ADD  = 3'd5,
    OP_TBL  = 3'd6
  } pc_op_e;
endpackage

// File: rtl/pcs_op_decode.sv
module pcs_op_decode
  import pcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   do_jump,
  input  logic   do_call,
  input  logic   do_return,
  input  logic   do_move,
  input  logic   do_add,
  input  logic   do_table,
  output pc_op_e op
);
  always_comb begin
    if (do_call)        op = OP_CALL;
    else if (do_return) op = OP_RET;
    else if (do_jump)   op = OP_JMP;
    else if (do_move)   op = OP_MOV;
    else if (do_add)    op = OP_ADD;
    else if (do_table)  op = OP_TBL;
    else                op = OP_SEQ;
  end

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_jump, do_call, do_return, do_move, do_add, do_table}));
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] top
);
  localparam int SP_W = $clog2(DEPTH);

  logic [DATA_W-1:0] slots [DEPTH];
  logic [SP_W-1:0]   sp_q;
  logic [SP_W-1:0]   sp_dn;

  assign sp_dn = sp_q - SP_W'(1);
  assign top   = slots[sp_dn];

  always_ff @(posedge clk) begin
    if (push) slots[sp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (push) sp_q <= sp_q + SP_W'(1);
    else if (pop)  sp_q <= sp_dn;
  end

  // R9
  push_store_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> (slots[$past(sp_q)] == $past(wdata)));

  // R9
  pop_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (sp_q == SP_W'($past(sp_q) - SP_W'(1))));

  // R1
  rst_ptr_chk: assert property (@(posedge clk)
    rst |=> (sp_q == '0));
endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
  import pcs_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 10,
  parameter int ACC_W  = 8
) (
  input  pc_op_e                     op,
  input  logic [PAGE_W+OFS_W-1:0]    pc,
  input  logic [PAGE_W+OFS_W-1:0]    stack_top,
  input  logic [PAGE_W-1:0]          page_sel,
  input  logic [OFS_W-1:0]           target,
  input  logic [ACC_W-1:0]           acc,
  output logic [PAGE_W+OFS_W-1:0]    pc_inc,
  output logic [PAGE_W+OFS_W-1:0]    pc_nxt
);
  localparam int ADDR_W = PAGE_W + OFS_W;
  localparam int GAP_W  = OFS_W - ACC_W;

  logic [ACC_W-1:0] low_sum;

  assign low_sum = pc[ACC_W-1:0] + acc;
  assign pc_inc  = pc + ADDR_W'(1);

  always_comb begin
    case (op)
      OP_JMP, OP_CALL: pc_nxt = {page_sel, target};
      OP_RET:          pc_nxt = stack_top;
      OP_MOV:          pc_nxt = {page_sel, {GAP_W{1'b0}}, acc};
      OP_ADD:          pc_nxt = {page_sel, {GAP_W{1'b0}}, low_sum};
      OP_TBL:          pc_nxt = {pc[ADDR_W-1:ACC_W], low_sum};
      default:         pc_nxt = pc_inc;
    endcase
  end
endmodule

// File: rtl/pcs_pc_unit.sv
module pcs_pc_unit
  import pcs_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 10,
  parameter int ACC_W  = 8,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       do_jump,
  input  logic                       do_call,
  input  logic                       do_return,
  input  logic                       do_move,
  input  logic                       do_add,
  input  logic                       do_table,
  input  logic [OFS_W-1:0]           target,
  input  logic [ACC_W-1:0]           acc,
  input  logic [PAGE_W-1:0]          page_sel,
  output logic [PAGE_W+OFS_W-1:0]    fetch_addr
);
  localparam int ADDR_W = PAGE_W + OFS_W;

  pc_op_e            op;
  logic [ADDR_W-1:0] pc_q, pc_nxt, pc_inc, stack_top;
  logic              no_strobe;

  assign no_strobe = !(do_jump || do_call || do_return || do_move || do_add || do_table);

  pcs_op_decode u_dec (
    .clk(clk), .rst(rst),
    .do_jump(do_jump), .do_call(do_call), .do_return(do_return),
    .do_move(do_move), .do_add(do_add), .do_table(do_table),
    .op(op)
  );

  pcs_ret_stack #(.DEPTH(DEPTH), .DATA_W(ADDR_W)) u_stk (
    .clk(clk), .rst(rst),
    .push(op == OP_CALL), .pop(op == OP_RET),
    .wdata(pc_inc), .top(stack_top)
  );

  pcs_next_pc #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .ACC_W(ACC_W)) u_nxt (
    .op(op), .pc(pc_q), .stack_top(stack_top),
    .page_sel(page_sel), .target(target), .acc(acc),
    .pc_inc(pc_inc), .pc_nxt(pc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign fetch_addr = pc_q;

  // R1
  rst_pc_chk: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    no_strobe |=> (fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(1))));

  // R3
  jump_load_chk: assert property (@(posedge clk) disable iff (rst)
    do_jump |=> (fetch_addr == {$past(page_sel), $past(target)}));

  // R6
  move_load_chk: assert property (@(posedge clk) disable iff (rst)
    do_move |=> (fetch_addr[OFS_W-1:ACC_W] == '0 && fetch_addr[ACC_W-1:0] == $past(acc)));

  // R8
  table_keep_chk: assert property (@(posedge clk) disable iff (rst)
    do_table |=> (fetch_addr[ADDR_W-1:ACC_W] == $past(fetch_addr[ADDR_W-1:ACC_W])));
endmodule

// File: tb/pcs_pc_unit_tb.sv
module pcs_pc_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic do_jump = 0, do_call = 0, do_return = 0, do_move = 0, do_add = 0, do_table = 0;
  logic [9:0]  target = '0;
  logic [7:0]  acc = '0;
  logic [3:0]  page_sel = '0;
  logic [13:0] fetch_addr;

  always #5 clk = ~clk;

  pcs_pc_unit dut_i (
    .clk(clk), .rst(rst),
    .do_jump(do_jump), .do_call(do_call), .do_return(do_return),
    .do_move(do_move), .do_add(do_add), .do_table(do_table),
    .target(target), .acc(acc), .page_sel(page_sel),
    .fetch_addr(fetch_addr)
  );

  int n_cmp = 0, n_bad = 0;
  int m_pc = 0;
  int m_ring [8];
  int m_sp = 0;
  bit done = 0;

  // op codes local to the bench: 0 seq,1 jump,2 call,3 ret,4 move,5 add,6 table,7 reset
  task automatic step(input int op, input int tg, input int ac, input int pg, input string req);
    int nxt;
    rst = (op == 7);
    do_jump = (op == 1); do_call = (op == 2); do_return = (op == 3);
    do_move = (op == 4); do_add = (op == 5); do_table = (op == 6);
    target = tg[9:0]; acc = ac[7:0]; page_sel = pg[3:0];
    case (op)
      7: begin nxt = 0; m_sp = 0; end
      1: nxt = pg * 1024 + tg;
      2: begin m_ring[m_sp] = (m_pc + 1) % 16384; m_sp = (m_sp + 1) % 8; nxt = pg * 1024 + tg; end
      3: begin m_sp = (m_sp + 7) % 8; nxt = m_ring[m_sp]; end
      4: nxt = pg * 1024 + ac;
      5: nxt = pg * 1024 + ((m_pc % 256 + ac) % 256);
      6: nxt = (m_pc / 256) * 256 + ((m_pc % 256 + ac) % 256);
      default: nxt = (m_pc + 1) % 16384;
    endcase
    m_pc = nxt;
    @(negedge clk);
    n_cmp++;
    if (fetch_addr !== 14'(m_pc)) begin
      n_bad++;
      $display("FAIL %s op%0d: actual %h expected %h", req, op, fetch_addr, 14'(m_pc));
    end
  endtask

  initial begin
    @(negedge clk);
    step(7, 0, 0, 0, "R1");
    step(7, 0, 0, 0, "R1");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R2");
    step(1, 10'h3FF, 0, 5, "R3");
    step(0, 0, 0, 0, "R2");
    step(1, 10'h3FF, 0, 15, "R3");
    step(0, 0, 0, 0, "R2 wrap");
    // fill the ring
    for (int i = 0; i < 8; i++) step(2, 37 * i + 3, 0, i + 2, "R4");
    step(3, 0, 0, 0, "R5");
    step(2, 10'h155, 0, 9, "R4");
    step(2, 10'h2AA, 0, 11, "R9 overwrite");
    for (int i = 0; i < 10; i++) step(3, 0, 0, 0, "R9 ring pop");
    // call followed at once by return
    step(2, 10'h123, 0, 4, "R4");
    step(3, 0, 0, 0, "R5");
    step(4, 0, 8'hA5, 6, "R6");
    step(1, 10'h3F0, 0, 3, "R3");
    step(5, 0, 8'h20, 7, "R7 carry");
    step(1, 10'h3F0, 0, 3, "R3");
    step(6, 0, 8'h20, 12, "R8 carry");
    step(1, 10'h2C8, 0, 1, "R3");
    step(6, 0, 8'h05, 0, "R8 keep 9:8");
    step(5, 0, 8'h05, 2, "R7 clear 9:8");
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 6);
      step(op, $urandom_range(0, 1023), $urandom_range(0, 255), $urandom_range(0, 15), "R9 mixed");
    end
    step(7, 0, 0, 0, "R1");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule